// File: doc/BRIEF.md
# One-Wire Bus Master

This block runs a single open-drain one-wire bus from a byte-wide register port. Software writes a command bit into the control register to start one of three bus operations. The first is a reset pulse followed by a window in which devices may answer with a presence pulse. The second is a time slot that writes a zero. The third is a time slot that writes a one and reads the bit a device returns in the same slot. The command bit stays set while its operation runs and clears itself at the end. The result bits are valid from the cycle in which the command bit reads zero.

All bus timing is counted in microsecond ticks. A programmable prescaler produces these ticks from the system clock. Software loads a divider value N, and the prescaler emits one tick every N+1 clocks. A soft-reset register aborts any operation and holds the engine idle for as long as its bit is set.

The line pin is modelled as a drive enable that pulls the bus low, plus a line input. The line input is synchronized before it is sampled. Byte framing, device search and checksums are left to software.

Top module: `owire_master`

## Requirements
- R1: After the synchronous reset `rst`, the control register (offset 0x0) reads 0x00, the divider (offset 0x2) reads 0x00, the soft-reset register (offset 0x4) reads 0x00 and `line_oe` is 0. Reads are registered: `rdata` shows the register selected by `addr` one clock later.
- R2: Control register bit layout:
  - bit 7 is the reset/presence command;
  - bit 6 is the presence result;
  - bit 5 is the write-0 command;
  - bit 4 is the write-1/read command;
  - bit 3 is the read-data result;
  - bits 2..0 read 0.

  Writing a 1 to a command bit while the block is idle starts that operation. The command bit reads 1 while the operation runs and reads 0 once it has finished.
- R3: If a single write sets more than one command bit, only one operation starts. The reset command wins over write-0, and write-0 wins over write-1/read.
- R4: A write to the control register while an operation is running is ignored. The running operation keeps its length and its result.
- R5: The reset/presence operation drives the line low for exactly 511 ticks. It then releases the line for a 512-tick presence window, so it lasts 1023 ticks in total.
- R6: The line is sampled at the 70th tick after release. The presence bit (bit 6) is 1 if the line was low at that point and 0 otherwise. It is updated when bit 7 clears.
- R7: A write-0 slot drives the line low for 60 ticks. It then releases the line for 1 tick of recovery before bit 5 clears, so it lasts 61 ticks.
- R8: A write-1/read slot drives the line low for 1 tick and samples the line at tick 15. It ends at tick 60. The sampled level is stored in bit 3 (1 = line high) when bit 4 clears.
- R9: The divider register at offset 0x2 reads back the value written, N. One tick lasts N+1 clock cycles, and the tick count restarts when an operation starts.
- R10: The soft-reset register at offset 0x4 has one bit, bit 0. While that bit is 1:
  - any running operation is aborted;
  - the control register reads 0x00;
  - the line is released;
  - control writes are ignored.

  The divider value is kept. Writing 0 to bit 0 lets the block accept commands again.
- R11: `line_oe` is 1 only during the drive-low phases of an operation. Outside those phases it is 0, whatever the level of the line. The line input goes through a two-flop synchronizer before it is sampled.

Port order is the order of the module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for `addr` |
| line_oe | output | 1 | Pull bus low when 1 (open drain) |
| line_in | input | 1 | Bus level as seen at the pin |

## Verification
The bench counts the exact number of clocks in which the line is driven low and the number of clocks in which the command bit reads 1. A design with an off-by-one in any phase counter, or one that ignores the divider, gives a different count. Multi-bit command writes and control writes made in the middle of a slot are applied. A wrong priority order, or an engine that restarts when a new command arrives while busy, changes the low time or leaves the wrong command bit set. A device model holds the line low, so presence and read data must follow the sampled line and not the master's own drive. Soft reset is asserted in the middle of the long reset pulse: a block that only masks the command bits would keep pulling the line low, or would lose the divider setting.

// File: rtl/owire_pkg.sv
package owire_pkg;
  // register byte offsets (software-visible map)
  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_DIV  = 2;
  localparam int unsigned OFF_SRST = 4;

  // control register bit positions
  localparam int unsigned B_RST_CMD = 7;
  localparam int unsigned B_PRES    = 6;
  localparam int unsigned B_W0_CMD  = 5;
  localparam int unsigned B_W1_CMD  = 4;
  localparam int unsigned B_RDBIT   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RLOW,
    ST_RWIN,
    ST_W0LOW,
    ST_W0REC,
    ST_SLOT
  } owire_st_t;
endpackage

// File: rtl/owire_tick.sv
module owire_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  // idle bus is high, so the chain resets to ones
  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/owire_engine.sv
module owire_engine
  import owire_pkg::*;
#(
  parameter int T_RLOW  = 511,
  parameter int T_RWIN  = 512,
  parameter int T_PSAMP = 70,
  parameter int T_SLOT  = 60,
  parameter int T_W1LOW = 1,
  parameter int T_RSAMP = 15,
  parameter int T_REC   = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_rst,
  input  logic       go_w0,
  input  logic       go_w1,
  input  logic       tick,
  input  logic       line_s,
  output logic [2:0] cmd,      // {reset, write0, write1/read}
  output logic       presence,
  output logic       rd_bit,
  output logic       line_oe
);
  localparam int MAXT  = (T_RWIN > T_RLOW) ? T_RWIN : T_RLOW;
  localparam int CNT_W = $clog2(MAXT) + 1;
  localparam logic [CNT_W-1:0] L_RLOW  = CNT_W'(T_RLOW - 1);
  localparam logic [CNT_W-1:0] L_RWIN  = CNT_W'(T_RWIN - 1);
  localparam logic [CNT_W-1:0] L_PSAMP = CNT_W'(T_PSAMP - 1);
  localparam logic [CNT_W-1:0] L_SLOT  = CNT_W'(T_SLOT - 1);
  localparam logic [CNT_W-1:0] L_W1LOW = CNT_W'(T_W1LOW - 1);
  localparam logic [CNT_W-1:0] L_RSAMP = CNT_W'(T_RSAMP - 1);
  localparam logic [CNT_W-1:0] L_REC   = CNT_W'(T_REC - 1);

  owire_st_t        st;
  logic [CNT_W-1:0] cnt;
  logic             samp;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      cmd      <= '0;
      presence <= 1'b0;
      rd_bit   <= 1'b0;
      line_oe  <= 1'b0;
      samp     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (go_rst) begin
            st <= ST_RLOW;  cmd <= 3'b100; line_oe <= 1'b1;
          end else if (go_w0) begin
            st <= ST_W0LOW; cmd <= 3'b010; line_oe <= 1'b1;
          end else if (go_w1) begin
            st <= ST_SLOT;  cmd <= 3'b001; line_oe <= 1'b1;
          end
        end
        ST_RLOW: if (tick) begin
          if (cnt == L_RLOW) begin
            st <= ST_RWIN; cnt <= '0; line_oe <= 1'b0; samp <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        ST_RWIN: if (tick) begin
          if (cnt == L_PSAMP) samp <= !line_s;
          if (cnt == L_RWIN) begin
            st <= ST_IDLE; cmd <= '0; presence <= samp; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_W0LOW: if (tick) begin
          if (cnt == L_SLOT) begin
            st <= ST_W0REC; cnt <= '0; line_oe <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        ST_W0REC: if (tick) begin
          if (cnt == L_REC) begin
            st <= ST_IDLE; cmd <= '0; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_SLOT: if (tick) begin
          if (cnt == L_W1LOW) line_oe <= 1'b0;
          if (cnt == L_RSAMP) samp <= line_s;
          if (cnt == L_SLOT) begin
            st <= ST_IDLE; cmd <= '0; rd_bit <= samp; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owire_master.sv
module owire_master
  import owire_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DIV_W   = 8,
  parameter int SYNC_N  = 2,
  parameter int T_RLOW  = 511,
  parameter int T_RWIN  = 512,
  parameter int T_PSAMP = 70,
  parameter int T_SLOT  = 60,
  parameter int T_W1LOW = 1,
  parameter int T_RSAMP = 15,
  parameter int T_REC   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              line_oe,
  input  logic              line_in
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFF_DIV);
  localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(OFF_SRST);

  logic [DIV_W-1:0] div_q;
  logic             srst_q;
  logic [2:0]       cmd;
  logic             presence, rd_bit, tick, line_s;
  logic             eng_rst, ctrl_wr, go_rst, go_w0, go_w1;

  assign eng_rst = rst | srst_q;
  assign ctrl_wr = wr_en && (addr == A_CTRL) && !srst_q && (cmd == 3'b000);
  assign go_rst  = ctrl_wr && wdata[B_RST_CMD];
  assign go_w0   = ctrl_wr && !wdata[B_RST_CMD] && wdata[B_W0_CMD];
  assign go_w1   = ctrl_wr && !wdata[B_RST_CMD] && !wdata[B_W0_CMD] && wdata[B_W1_CMD];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      srst_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_DIV)  div_q  <= wdata[DIV_W-1:0];
      if (addr == A_SRST) srst_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      rdata <= '0;
      if (addr == A_CTRL) begin
        rdata[B_RST_CMD] <= cmd[2];
        rdata[B_PRES]    <= presence;
        rdata[B_W0_CMD]  <= cmd[1];
        rdata[B_W1_CMD]  <= cmd[0];
        rdata[B_RDBIT]   <= rd_bit;
      end else if (addr == A_DIV) rdata[DIV_W-1:0] <= div_q;
      else if (addr == A_SRST)    rdata[0] <= srst_q;
    end
  end

  owire_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(eng_rst), .restart(go_rst | go_w0 | go_w1),
    .div(div_q), .tick(tick)
  );

  owire_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(line_s)
  );

  owire_engine #(
    .T_RLOW(T_RLOW), .T_RWIN(T_RWIN), .T_PSAMP(T_PSAMP), .T_SLOT(T_SLOT),
    .T_W1LOW(T_W1LOW), .T_RSAMP(T_RSAMP), .T_REC(T_REC)
  ) u_eng (
    .clk(clk), .rst(eng_rst), .go_rst(go_rst), .go_w0(go_w0), .go_w1(go_w1),
    .tick(tick), .line_s(line_s), .cmd(cmd), .presence(presence),
    .rd_bit(rd_bit), .line_oe(line_oe)
  );
endmodule

// File: rtl/owire_master_chk.sv
module owire_master_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              line_oe,
  input logic [2:0]        cmd,
  input logic              srst_q
);
  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd)); // R2

  AST_OE_IN_OP: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> (cmd != 3'b000)); // R11

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd != 3'b000 && !srst_q) |=> (cmd == 3'b000 || $stable(cmd))); // R4

  AST_RST_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(0) && wdata[7] && cmd == 3'b000 && !srst_q)
      |=> (cmd == 3'b100)); // R3

  AST_SRST_IDLE: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (cmd == 3'b000 && !line_oe)); // R10
endmodule

bind owire_master owire_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .line_oe(line_oe), .cmd(cmd), .srst_q(srst_q)
);

// File: tb/owire_master_tb.sv
module owire_master_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       line_oe;
  logic       dev_hold = 1'b0;
  logic       line_in;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign line_in = !(line_oe || dev_hold);

  owire_master u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .line_oe(line_oe), .line_in(line_in)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata; addr = '0;
  endtask

  // start a command, optionally inject a control write at cycle 10,
  // count clocks with line driven low and clocks with a command bit set
  task automatic run_op(input logic [7:0] c, input logic [7:0] inj,
                        output int low, output int busy, output logic [7:0] fin);
    low = 0; busy = 0;
    @(negedge clk); wr_en = 1'b1; addr = 3'h0; wdata = c;
    @(negedge clk); wr_en = 1'b0;
    for (int i = 0; i < 100000; i++) begin
      if (i == 11) wr_en = 1'b0;
      if (i == 10 && inj != 8'h00) begin wr_en = 1'b1; wdata = inj; end
      if (line_oe) low++;
      if ((rdata & 8'hB0) != 0) busy++;
      if (i > 2 && (rdata & 8'hB0) == 0) break;
      @(negedge clk);
    end
    wr_en = 1'b0;
    fin = rdata;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    rd(3'h0, d); check("R1 ctrl", d, 0);
    rd(3'h2, d); check("R1 div", d, 0);
    rd(3'h4, d); check("R1 srst", d, 0);
    check("R1 line_oe", line_oe, 0);
  endtask

  task automatic t_presence(input logic hold);
    int lo, bz; logic [7:0] f;
    dev_hold = hold;
    run_op(8'h80, 8'h00, lo, bz, f);
    check("R5 reset low", lo, 511);
    check("R5 reset total", bz, 1023);
    check("R6 presence", f[6], hold);
    check("R2 cmd cleared", f & 8'hB0, 0);
    dev_hold = 1'b0;
  endtask

  task automatic t_write0();
    int lo, bz; logic [7:0] f;
    run_op(8'h20, 8'h00, lo, bz, f);
    check("R7 w0 low", lo, 60);
    check("R7 w0 total", bz, 61);
    check("R2 w0 cleared", f & 8'hB0, 0);
  endtask

  task automatic t_read(input logic hold);
    int lo, bz; logic [7:0] f;
    dev_hold = hold;
    run_op(8'h10, 8'h00, lo, bz, f);
    check("R8 w1 low", lo, 1);
    check("R8 slot total", bz, 60);
    check("R8 read bit", f[3], !hold);
    repeat (3) @(negedge clk);
    check("R11 idle released", line_oe, 0);
    dev_hold = 1'b0;
  endtask

  task automatic t_priority();
    int lo, bz; logic [7:0] f;
    run_op(8'hB0, 8'h00, lo, bz, f);
    check("R3 all set -> reset", lo, 511);
    run_op(8'h30, 8'h00, lo, bz, f);
    check("R3 w0 over w1 low", lo, 60);
    check("R3 w0 over w1 total", bz, 61);
  endtask

  task automatic t_busy_ignore();
    int lo, bz; logic [7:0] f;
    dev_hold = 1'b1;
    run_op(8'h20, 8'h80, lo, bz, f);
    check("R4 low unchanged", lo, 60);
    check("R4 total unchanged", bz, 61);
    check("R4 no presence", f[6], 0);
    dev_hold = 1'b0;
  endtask

  task automatic t_divider();
    int lo, bz; logic [7:0] f; logic [7:0] d;
    wr(3'h2, 8'd4);
    rd(3'h2, d); check("R9 div readback", d, 4);
    run_op(8'h10, 8'h00, lo, bz, f);
    check("R9 w1 low div4", lo, 5);
    check("R9 slot div4", bz, 300);
    run_op(8'h20, 8'h00, lo, bz, f);
    check("R9 w0 low div4", lo, 300);
  endtask

  task automatic t_soft_reset();
    int lo, bz; logic [7:0] f; logic [7:0] d;
    wr(3'h2, 8'd2);
    wr(3'h0, 8'h80);
    repeat (50) @(negedge clk);
    check("R10 pre line low", line_oe, 1);
    wr(3'h4, 8'h01);
    repeat (2) @(negedge clk);
    check("R10 line released", line_oe, 0);
    rd(3'h0, d); check("R10 ctrl cleared", d, 0);
    wr(3'h0, 8'h10);
    repeat (3) @(negedge clk);
    check("R10 cmd ignored oe", line_oe, 0);
    rd(3'h0, d); check("R10 cmd ignored ctrl", d, 0);
    wr(3'h4, 8'h00);
    rd(3'h2, d); check("R10 div kept", d, 2);
    run_op(8'h10, 8'h00, lo, bz, f);
    check("R10 runs after release", lo, 3);
    wr(3'h2, 8'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_presence(1'b1);
    t_presence(1'b0);
    t_write0();
    t_read(1'b0);
    t_read(1'b1);
    t_priority();
    t_busy_ignore();
    t_divider();
    wr(3'h2, 8'd0);
    t_soft_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule